// File: doc/BRIEF.md
# Swizzled Banked Tile Scratchpad

This block is a shared on-chip scratchpad built from 32 banks, each 4 bytes wide, so one physical row spans 128 bytes and touches every bank exactly once. Matrix tiles are held in indivisible 16-byte chunks. A chunk covers four neighbouring banks, and a physical row therefore has eight chunk slots. A selectable placement mode (none, 32B, 64B or 128B) permutes whole chunks within each row as a function of the row index. The aim is that a column-shaped subtile, 8 rows deep and 16 bytes wide, can be gathered with each chunk coming from a different group of banks.

The write port stores one complete 128-byte line per cycle. The line's data is given in logical slot order, and the block scatters each chunk to its physical slot. The read port takes eight independent logical (line, slot) coordinates, one per lane, and gathers the eight chunks. For each gather it reports whether two lanes landed on the same bank group, and how many cycles a banked memory would need to serve the gather. Reads and writes go through the same address mapping, so any chunk written under a mode reads back unchanged under that mode. The mode register changes only in a cycle with no access.

Top module: `swz_scratchpad`

## Requirements
- R1: A write stores the 1024-bit `wr_data` into line `wr_line`, with logical slot k carried on bits [128k+127:128k]. A read started with `rd_en` presents lane i's chunk on `rd_data[128i+127:128i]` with `rd_valid` high after exactly one rising edge.
- R2: The physical slot of a chunk is its logical slot XOR (line[2:0] AND M). M is 0, 1, 3 or 7 for the mode codes 0 (none), 1 (32B), 2 (64B) and 3 (128B).
- R3: When a chunk is written and then read under the same mode, the read returns the chunk as it was written, for any line and any slot.
- R4: In 64B mode, physical line 1 holds logical slots in the order 1,0,3,2,5,4,7,6. Data written to line 1 under mode none and read in 64B mode at logical slot s therefore returns the chunk written at slot s^1.
- R5: In 32B mode, a 32-byte-wide tile stored in lines 0 and 1 gives conflict-free column subtiles. The even subtile is lines 0,0,0,0,1,1,1,1 at slots 0,2,4,6,0,2,4,6. The odd subtile is the same lines at slots 1,3,5,7,1,3,5,7. Each reports `rd_conflict`=0 and `rd_cycles`=1.
- R6: In mode none, the same even subtile maps two lanes onto each of four bank groups and reports `rd_conflict`=1 and `rd_cycles`=2.
- R7: In 128B mode, a column of lines 0..7 at one fixed slot reads with `rd_cycles`=1. In mode none, the same column reports `rd_conflict`=1 and `rd_cycles`=8.
- R8: `rd_cycles` equals the largest number of lanes whose physical slot falls in one bank group, in the range 1..8. `rd_conflict` is 1 exactly when that number exceeds 1.
- R9: `mode_req` is copied into the mode register only at an edge where both `wr_en` and `rd_en` are low. Accesses from the following cycle use the new mode. A `mode_req` value present only during access cycles is ignored.
- R10: During and right after reset, `rd_valid`, `rd_conflict`, `rd_cycles` and `rd_data` are zero and the mode is none. Storage contents are not cleared.
- R11: When a read and a write address the same line in the same cycle, the read returns the data held before that write.
- R12: After a cycle with `rd_en` low, `rd_valid` and `rd_conflict` are 0, while `rd_data` and `rd_cycles` keep their last values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_req | input | 2 | Requested placement mode: 0 none, 1 32B, 2 64B, 3 128B |
| wr_en | input | 1 | Write one full line this cycle |
| wr_line | input | 4 | Line index of the write |
| wr_data | input | 1024 | Line data, eight 128-bit chunks in logical slot order |
| rd_en | input | 1 | Start a gather this cycle |
| rd_line | input | 32 | Per-lane line index, lane i at bits [4i+3:4i] |
| rd_slot | input | 24 | Per-lane logical slot, lane i at bits [3i+2:3i] |
| rd_valid | output | 1 | Gather result present |
| rd_data | output | 1024 | Gathered chunks, lane i at bits [128i+127:128i] |
| rd_conflict | output | 1 | Two or more lanes hit one bank group |
| rd_cycles | output | 4 | Cycles a banked access would need |

## Verification
Every result appears one rising edge after the cycle that causes it. Gather data, the conflict flag and the cycle count all come out of the edge that samples `rd_en`. A mode adopted at an idle edge affects only accesses driven after that edge. The bench drives each stimulus just after a falling edge and samples the outputs at the next falling edge, which sits half a period after the single register stage. The mode tests insert an explicit idle cycle before the access that depends on the new mode. The same-cycle test samples the first read before the competing write can be seen.

// File: rtl/swz_pkg.sv
package swz_pkg;

   typedef enum logic [1:0] {
      SWZ_NONE = 2'd0,
      SWZ_32B  = 2'd1,
      SWZ_64B  = 2'd2,
      SWZ_128B = 2'd3
   } swz_mode_e;

   // XOR key applied to a chunk slot, taken from the low line bits
   function automatic logic [2:0] swz_key(input swz_mode_e mode, input logic [2:0] low);
      logic [2:0] k;
      case (mode)
         SWZ_32B:  k = {2'b00, low[0]};
         SWZ_64B:  k = {1'b0, low[1:0]};
         SWZ_128B: k = low;
         default:  k = 3'd0;
      endcase
      return k;
   endfunction

endpackage

// File: rtl/swz_map.sv
module swz_map
   import swz_pkg::*;
(
   input  swz_mode_e  mode,
   input  logic [2:0] line_lo,
   input  logic [2:0] slot,
   output logic [2:0] pslot
);

   assign pslot = slot ^ swz_key(mode, line_lo);

endmodule

// File: rtl/swz_bank_count.sv
module swz_bank_count #(
   parameter int LANES  = 8,
   parameter int SLOTS  = 8,
   parameter int SLOT_W = 3,
   parameter int CNT_W  = 4
) (
   input  logic [LANES*SLOT_W-1:0] pslots,
   output logic [CNT_W-1:0]        max_cnt
);

   logic [CNT_W-1:0] cnt;
   logic [CNT_W-1:0] best;

   always_comb begin
      best = '0;
      cnt  = '0;
      for (int g = 0; g < SLOTS; g++) begin
         cnt = '0;
         for (int i = 0; i < LANES; i++) begin
            if (pslots[i*SLOT_W +: SLOT_W] == SLOT_W'(g))
               cnt = cnt + CNT_W'(1);
         end
         if (cnt > best)
            best = cnt;
      end
      max_cnt = best;
   end

endmodule

// File: rtl/swz_store.sv
module swz_store #(
   parameter int NROWS      = 16,
   parameter int SLOTS      = 8,
   parameter int SLOT_W     = 3,
   parameter int CHUNK_BITS = 128,
   parameter int LANES      = 8,
   localparam int LINE_W    = $clog2(NROWS),
   localparam int ROW_BITS  = SLOTS * CHUNK_BITS
) (
   input  logic                        clk,
   input  logic                        wr_en,
   input  logic [LINE_W-1:0]           wr_line,
   input  logic [SLOT_W-1:0]           wr_key,
   input  logic [ROW_BITS-1:0]         wr_data,
   input  logic [LANES*LINE_W-1:0]     rd_lines,
   input  logic [LANES*SLOT_W-1:0]     rd_pslots,
   output logic [LANES*CHUNK_BITS-1:0] rd_chunks
);

   logic [CHUNK_BITS-1:0] mem [NROWS][SLOTS];

   // physical slot p receives logical slot p ^ key
   always_ff @(posedge clk) begin
      if (wr_en) begin
         for (int p = 0; p < SLOTS; p++)
            mem[wr_line][p] <= wr_data[(SLOT_W'(p) ^ wr_key)*CHUNK_BITS +: CHUNK_BITS];
      end
   end

   for (genvar i = 0; i < LANES; i++) begin : g_lane
      assign rd_chunks[i*CHUNK_BITS +: CHUNK_BITS] =
         mem[rd_lines[i*LINE_W +: LINE_W]][rd_pslots[i*SLOT_W +: SLOT_W]];
   end

endmodule

// File: rtl/swz_scratchpad.sv
module swz_scratchpad
   import swz_pkg::*;
#(
   parameter int NROWS       = 16,
   parameter int BANKS       = 32,
   parameter int BANK_BYTES  = 4,
   parameter int CHUNK_BYTES = 16,
   parameter int LANES       = 8,
   localparam int ROW_BITS   = BANKS * BANK_BYTES * 8,
   localparam int CHUNK_BITS = CHUNK_BYTES * 8,
   localparam int SLOTS      = ROW_BITS / CHUNK_BITS,
   localparam int SLOT_W     = $clog2(SLOTS),
   localparam int LINE_W     = $clog2(NROWS),
   localparam int CNT_W      = $clog2(LANES + 1)
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic [1:0]                  mode_req,
   input  logic                        wr_en,
   input  logic [LINE_W-1:0]           wr_line,
   input  logic [ROW_BITS-1:0]         wr_data,
   input  logic                        rd_en,
   input  logic [LANES*LINE_W-1:0]     rd_line,
   input  logic [LANES*SLOT_W-1:0]     rd_slot,
   output logic                        rd_valid,
   output logic [LANES*CHUNK_BITS-1:0] rd_data,
   output logic                        rd_conflict,
   output logic [CNT_W-1:0]            rd_cycles
);

   if (ROW_BITS % CHUNK_BITS != 0) begin : g_bad_chunk
      $error("chunk size must divide the row size");
   end
   if (SLOTS != 8) begin : g_bad_slots
      $error("placement modes assume eight chunk slots per row");
   end
   if (NROWS < 8 || (NROWS & (NROWS - 1)) != 0) begin : g_bad_rows
      $error("NROWS must be a power of two of at least 8");
   end
   if (LANES < 1) begin : g_bad_lanes
      $error("LANES must be at least 1");
   end

   swz_mode_e mode_q;

   always_ff @(posedge clk) begin
      if (!rst_n)
         mode_q <= SWZ_NONE;
      else if (!wr_en && !rd_en)
         mode_q <= swz_mode_e'(mode_req);
   end

   logic [LANES*SLOT_W-1:0] pslots;

   for (genvar i = 0; i < LANES; i++) begin : g_map
      swz_map u_map (
         .mode    (mode_q),
         .line_lo (rd_line[i*LINE_W +: 3]),
         .slot    (rd_slot[i*SLOT_W +: SLOT_W]),
         .pslot   (pslots[i*SLOT_W +: SLOT_W])
      );
   end

   logic [LANES*CHUNK_BITS-1:0] gathered;
   logic [CNT_W-1:0]            worst;

   swz_store #(
      .NROWS      (NROWS),
      .SLOTS      (SLOTS),
      .SLOT_W     (SLOT_W),
      .CHUNK_BITS (CHUNK_BITS),
      .LANES      (LANES)
   ) u_store (
      .clk       (clk),
      .wr_en     (wr_en),
      .wr_line   (wr_line),
      .wr_key    (swz_key(mode_q, wr_line[2:0])),
      .wr_data   (wr_data),
      .rd_lines  (rd_line),
      .rd_pslots (pslots),
      .rd_chunks (gathered)
   );

   swz_bank_count #(
      .LANES  (LANES),
      .SLOTS  (SLOTS),
      .SLOT_W (SLOT_W),
      .CNT_W  (CNT_W)
   ) u_count (
      .pslots  (pslots),
      .max_cnt (worst)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rd_valid    <= 1'b0;
         rd_data     <= '0;
         rd_conflict <= 1'b0;
         rd_cycles   <= '0;
      end else begin
         rd_valid <= rd_en;
         if (rd_en) begin
            rd_data     <= gathered;
            rd_conflict <= (worst > CNT_W'(1));
            rd_cycles   <= worst;
         end else begin
            rd_conflict <= 1'b0;
         end
      end
   end

endmodule

// File: rtl/swz_scratchpad_chk.sv
module swz_scratchpad_chk #(
   parameter int LANES = 8,
   parameter int CNT_W = 4
) (
   input logic             clk,
   input logic             rst_n,
   input logic             wr_en,
   input logic             rd_en,
   input logic             rd_valid,
   input logic             rd_conflict,
   input logic [CNT_W-1:0] rd_cycles,
   input logic [1:0]       mode_q
);

   // R1
   valid_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_en |=> rd_valid);

   // R12
   idle_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_en |=> !rd_valid);

   // R12
   quiet_conflict_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_valid |-> !rd_conflict);

   // R8
   cycles_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid |-> (rd_cycles >= CNT_W'(1) && rd_cycles <= CNT_W'(LANES)));

   // R9
   mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en || rd_en) |=> $stable(mode_q));

endmodule

bind swz_scratchpad swz_scratchpad_chk #(
   .LANES (LANES),
   .CNT_W (CNT_W)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .wr_en       (wr_en),
   .rd_en       (rd_en),
   .rd_valid    (rd_valid),
   .rd_conflict (rd_conflict),
   .rd_cycles   (rd_cycles),
   .mode_q      (mode_q)
);

// File: tb/sim_swz_scratchpad.sv
module sim_swz_scratchpad;

   localparam int LW = 4;
   localparam int SW = 3;
   localparam int CB = 128;
   localparam int NL = 8;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic [1:0]      mode_req = 2'd0;
   logic            wr_en = 1'b0;
   logic [LW-1:0]   wr_line = '0;
   logic [1023:0]   wr_data = '0;
   logic            rd_en = 1'b0;
   logic [NL*LW-1:0] rd_line = '0;
   logic [NL*SW-1:0] rd_slot = '0;
   logic            rd_valid;
   logic [NL*CB-1:0] rd_data;
   logic            rd_conflict;
   logic [3:0]      rd_cycles;

   int n_checks = 0;
   int n_errors = 0;
   int lane_line [NL];
   int lane_slot [NL];

   always #5 clk = ~clk;

   swz_scratchpad u0 (
      .clk (clk), .rst_n (rst_n), .mode_req (mode_req),
      .wr_en (wr_en), .wr_line (wr_line), .wr_data (wr_data),
      .rd_en (rd_en), .rd_line (rd_line), .rd_slot (rd_slot),
      .rd_valid (rd_valid), .rd_data (rd_data),
      .rd_conflict (rd_conflict), .rd_cycles (rd_cycles)
   );

   function automatic logic [CB-1:0] mk(int l, int s);
      return {4{8'hA5, 8'(l), 8'(s), 8'h3C}};
   endfunction

   task automatic chk(string tag, logic [CB-1:0] act, logic [CB-1:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // tasks start and end right after a falling edge
   task automatic set_mode(int m);
      mode_req = 2'(m);
      @(negedge clk);
   endtask

   task automatic write_line(int l, bit invert);
      wr_en = 1'b1;
      wr_line = LW'(l);
      for (int k = 0; k < NL; k++)
         wr_data[k*CB +: CB] = invert ? ~mk(l, k) : mk(l, k);
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic load_lanes();
      for (int i = 0; i < NL; i++) begin
         rd_line[i*LW +: LW] = LW'(lane_line[i]);
         rd_slot[i*SW +: SW] = SW'(lane_slot[i]);
      end
   endtask

   task automatic do_read();
      load_lanes();
      rd_en = 1'b1;
      @(negedge clk);
      rd_en = 1'b0;
   endtask

   task automatic t_reset();
      chk("R10 rd_valid", CB'(rd_valid), '0);
      chk("R10 rd_conflict", CB'(rd_conflict), '0);
      chk("R10 rd_cycles", CB'(rd_cycles), '0);
      chk("R10 rd_data", CB'(rd_data == '0), CB'(1));
   endtask

   task automatic t_roundtrip();
      set_mode(3);
      for (int l = 0; l < 8; l++) write_line(l, 1'b0);
      for (int i = 0; i < NL; i++) begin
         lane_line[i] = i; lane_slot[i] = (i + 3) % 8;
      end
      do_read();
      chk("R1 rd_valid after one edge", CB'(rd_valid), CB'(1));
      for (int i = 0; i < NL; i++)
         chk($sformatf("R3 lane %0d", i), rd_data[i*CB +: CB], mk(i, (i + 3) % 8));
   endtask

   task automatic t_64b_order();
      set_mode(0);
      write_line(1, 1'b0);
      write_line(10, 1'b0);
      set_mode(2);
      for (int i = 0; i < NL; i++) begin
         lane_line[i] = 1; lane_slot[i] = i;
      end
      do_read();
      for (int i = 0; i < NL; i++)
         chk($sformatf("R4 line1 slot %0d", i), rd_data[i*CB +: CB], mk(1, i ^ 1));
      for (int i = 0; i < NL; i++) begin
         lane_line[i] = 10; lane_slot[i] = i;
      end
      do_read();
      for (int i = 0; i < NL; i++)
         chk($sformatf("R2 line10 slot %0d", i), rd_data[i*CB +: CB], mk(10, i ^ 2));
   endtask

   task automatic tile32(int odd);
      for (int m = 0; m < NL; m++) begin
         lane_line[m] = m / 4; lane_slot[m] = (m % 4) * 2 + odd;
      end
   endtask

   task automatic t_32b_subtile();
      set_mode(1);
      tile32(0);
      do_read();
      chk("R5 even conflict", CB'(rd_conflict), '0);
      chk("R5 even cycles", CB'(rd_cycles), CB'(1));
      tile32(1);
      do_read();
      chk("R5 odd conflict", CB'(rd_conflict), '0);
      chk("R5 odd cycles", CB'(rd_cycles), CB'(1));
   endtask

   task automatic t_linear_conflict();
      set_mode(0);
      tile32(0);
      do_read();
      chk("R6 conflict", CB'(rd_conflict), CB'(1));
      chk("R6 cycles", CB'(rd_cycles), CB'(2));
   endtask

   task automatic t_128b_column();
      for (int i = 0; i < NL; i++) begin
         lane_line[i] = i; lane_slot[i] = 2;
      end
      set_mode(3);
      do_read();
      chk("R7 128B cycles", CB'(rd_cycles), CB'(1));
      chk("R7 128B conflict", CB'(rd_conflict), '0);
      set_mode(0);
      do_read();
      chk("R7 none cycles", CB'(rd_cycles), CB'(8));
      chk("R7 none conflict", CB'(rd_conflict), CB'(1));
   endtask

   task automatic t_counts();
      for (int m = 0; m < NL; m++) begin
         lane_line[m] = m / 2; lane_slot[m] = (m % 2) * 4 + 1;
      end
      set_mode(2);
      do_read();
      chk("R8 64B column cycles", CB'(rd_cycles), CB'(1));
      set_mode(0);
      do_read();
      chk("R8 none 64B-tile cycles", CB'(rd_cycles), CB'(4));
      chk("R8 none 64B-tile conflict", CB'(rd_conflict), CB'(1));
      for (int i = 0; i < NL; i++) lane_line[i] = 0;
      lane_slot = '{5, 5, 5, 0, 1, 2, 3, 4};
      do_read();
      chk("R8 triple cycles", CB'(rd_cycles), CB'(3));
   endtask

   task automatic t_mode_ignored();
      set_mode(0);
      for (int i = 0; i < NL; i++) begin
         lane_line[i] = 1; lane_slot[i] = i;
      end
      // request 128B only while a write is in progress
      mode_req = 2'd3;
      write_line(1, 1'b0);
      mode_req = 2'd0;
      do_read();
      for (int i = 0; i < 2; i++)
         chk($sformatf("R9 ignored slot %0d", i), rd_data[i*CB +: CB], mk(1, i));
      // request 128B only while a read is in progress
      mode_req = 2'd3;
      do_read();
      mode_req = 2'd0;
      do_read();
      chk("R9 ignored during read", rd_data[0 +: CB], mk(1, 0));
      set_mode(3);
      do_read();
      chk("R9 adopted after idle", rd_data[0 +: CB], mk(1, 1));
   endtask

   task automatic t_same_cycle();
      set_mode(0);
      write_line(12, 1'b0);
      for (int i = 0; i < NL; i++) begin
         lane_line[i] = 12; lane_slot[i] = i;
      end
      load_lanes();
      rd_en = 1'b1;
      write_line(12, 1'b1);
      rd_en = 1'b0;
      chk("R11 old data lane 0", rd_data[0 +: CB], mk(12, 0));
      chk("R11 old data lane 7", rd_data[7*CB +: CB], mk(12, 7));
      do_read();
      chk("R11 new data lane 3", rd_data[3*CB +: CB], ~mk(12, 3));
   endtask

   task automatic t_idle();
      set_mode(0);
      tile32(0);
      do_read();
      @(negedge clk);
      chk("R12 idle rd_valid", CB'(rd_valid), '0);
      chk("R12 idle rd_conflict", CB'(rd_conflict), '0);
      chk("R12 idle rd_cycles held", CB'(rd_cycles), CB'(2));
      chk("R12 idle rd_data held", rd_data[4*CB +: CB], mk(1, 0));
   endtask

   initial begin
      #(200000 * 10);
      n_checks++;
      n_errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", n_checks, n_errors);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_roundtrip();
      t_64b_order();
      t_32b_subtile();
      t_linear_conflict();
      t_128b_column();
      t_counts();
      t_mode_ignored();
      t_same_cycle();
      t_idle();
      $display("  CHECKS %0d ERRORS %0d", n_checks, n_errors);
      $finish;
   end

endmodule